// File: doc/BRIEF.md
# Frequency-Correction Burst Sequencer

This block produces the serial bit stream for a repeating TDMA frame of eight timeslots. Every timeslot holds a frequency-correction burst. The burst is an active portion of constant zero bits followed by a guard period made of whole bits. The burst contents are fixed, so the block has no data-load input. The bit-period timing comes from an external strobe. On each strobe the block presents one bit and marks whether that bit is active burst or guard.

The active portion is 148 bits long. It is a 3-bit zero tail, then 142 fixed zero bits, then a closing 3-bit zero tail. The guard length depends on the slot number. Slots 0 and 4 carry a 9-bit guard, which makes them 157 bit periods long. All other slots carry an 8-bit guard, which makes them 156 bit periods long. The frame therefore averages the nominal 156.25 bit periods per slot exactly, and one frame lasts 1250 bit periods.

The outputs are combinational decodes of the current position. They describe the bit that is being emitted now, and the position moves forward on the clock edge where the strobe is taken. An enable input freezes the position and silences the gate. When the enable returns, the sequence continues from the frozen position.

Top module: `fcBurstSeq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the position at slot 0, bit 0.
- R2: The position advances by one bit at a clock edge only when both `enable` and `bitStrobe` are high. Otherwise `slotNum` and `bitIdx` hold their values.
- R3: `bitIdx` counts 0 to 156 in slots 0 and 4, and 0 to 155 in every other slot. After the last index it returns to 0.
- R4: When a slot ends, `slotNum` steps to the next slot. Slot 7 is followed by slot 0.
- R5: While `enable` is high, `gateOn` is 1 for `bitIdx` 0 to 147 and 0 for the guard bits that follow.
- R6: `dataBit` is 0 for every position. This covers the tails, the fixed field and the guard.
- R7: `frameStart` is 1 exactly when `enable` and `bitStrobe` are both high and the position is slot 0, bit 0.
- R8: While `enable` is low, `gateOn` and `frameStart` are 0 and the position is frozen. After `enable` returns, counting resumes from the frozen position.
- R9: With `enable` held high, consecutive `frameStart` pulses are separated by exactly 1250 taken strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run control. When low, the position freezes and the gate is forced off |
| bitStrobe | input | 1 | One-cycle pulse marking the end of the current bit period |
| dataBit | output | 1 | Serial burst bit for the current position |
| gateOn | output | 1 | High while the current bit is active burst |
| slotNum | output | 3 | Current timeslot, 0 to 7 |
| bitIdx | output | 8 | Bit index within the current slot |
| frameStart | output | 1 | Qualified strobe on the first bit of slot 0 |

## Verification
The assertions assume that `enable` and `bitStrobe` are clean synchronous levels with no unknown values after reset. They also take the strobe as sampled on each clock edge, so back-to-back strobes are legal. The stimulus uses several strobe patterns: a strobe on every cycle, strobes in sparse and irregular gaps, and strobes arriving while `enable` is low. It also applies reset in the middle of a frame. Inputs are only ever changed away from the active edge, so each sampled value is unambiguous.

// File: rtl/fcbPkg.sv
package fcbPkg;
  // Kind of field holding the current bit
  typedef enum logic [1:0] {
    FIELD_HEAD  = 2'd0,
    FIELD_FIXED = 2'd1,
    FIELD_TAIL  = 2'd2,
    FIELD_GUARD = 2'd3
  } fcbFieldT;

  // Strobes from control to datapath
  typedef struct packed {
    logic     advance;   // take one bit step this edge
    logic     slotEnd;   // current bit is the last of its slot
    logic     gateEn;    // current bit is active and block enabled
    fcbFieldT field;     // field of the current bit
  } fcbCtrlT;
endpackage

// File: rtl/fcbCtrl.sv
module fcbCtrl
  import fcbPkg::*;
#(
  parameter int TAIL_LEN    = 3,
  parameter int FIXED_LEN   = 142,
  parameter int GUARD_SHORT = 8,
  parameter int GUARD_LONG  = 9,
  parameter int SLOTS       = 8,
  parameter int LONG_A      = 0,
  parameter int LONG_B      = 4,
  parameter int SLOT_W      = 3,
  parameter int IDX_W       = 8
) (
  input  logic              enable,
  input  logic              bitStrobe,
  input  logic [SLOT_W-1:0] slotNum,
  input  logic [IDX_W-1:0]  bitIdx,
  output fcbCtrlT           ctrl
);
  localparam int ACTIVE_LEN = 2 * TAIL_LEN + FIXED_LEN;
  localparam logic [IDX_W-1:0] HEAD_END   = IDX_W'(TAIL_LEN);
  localparam logic [IDX_W-1:0] FIXED_END  = IDX_W'(TAIL_LEN + FIXED_LEN);
  localparam logic [IDX_W-1:0] ACTIVE_END = IDX_W'(ACTIVE_LEN);
  localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(ACTIVE_LEN + GUARD_LONG - 1);
  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(ACTIVE_LEN + GUARD_SHORT - 1);

  logic     longSlot;
  fcbFieldT fieldNow;

  assign longSlot = (slotNum == SLOT_W'(LONG_A)) || (slotNum == SLOT_W'(LONG_B));

  always_comb begin
    if (bitIdx < HEAD_END)        fieldNow = FIELD_HEAD;
    else if (bitIdx < FIXED_END)  fieldNow = FIELD_FIXED;
    else if (bitIdx < ACTIVE_END) fieldNow = FIELD_TAIL;
    else                          fieldNow = FIELD_GUARD;
  end

  always_comb begin
    ctrl.advance = enable && bitStrobe;
    ctrl.slotEnd = longSlot ? (bitIdx == LAST_LONG) : (bitIdx == LAST_SHORT);
    ctrl.gateEn  = enable && (fieldNow != FIELD_GUARD);
    ctrl.field   = fieldNow;
  end
endmodule

// File: rtl/fcbDatapath.sv
module fcbDatapath
  import fcbPkg::*;
#(
  parameter int   SLOTS     = 8,
  parameter int   SLOT_W    = 3,
  parameter int   IDX_W     = 8,
  parameter logic TAIL_VAL  = 1'b0,
  parameter logic FIXED_VAL = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  fcbCtrlT           ctrl,
  output logic [SLOT_W-1:0] slotNum,
  output logic [IDX_W-1:0]  bitIdx,
  output logic              dataBit,
  output logic              gateOn,
  output logic              frameStart
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      slotNum <= '0;
      bitIdx  <= '0;
    end else if (ctrl.advance) begin
      if (ctrl.slotEnd) begin
        bitIdx  <= '0;
        slotNum <= (slotNum == LAST_SLOT) ? '0 : slotNum + 1'b1;
      end else begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  always_comb begin
    gateOn = ctrl.gateEn;
    unique case (ctrl.field)
      FIELD_HEAD, FIELD_TAIL: dataBit = ctrl.gateEn & TAIL_VAL;
      FIELD_FIXED:            dataBit = ctrl.gateEn & FIXED_VAL;
      default:                dataBit = 1'b0;
    endcase
    frameStart = ctrl.advance && (slotNum == '0) && (bitIdx == '0);
  end
endmodule

// File: rtl/fcBurstSeq.sv
module fcBurstSeq
  import fcbPkg::*;
#(
  parameter int TAIL_LEN    = 3,
  parameter int FIXED_LEN   = 142,
  parameter int GUARD_SHORT = 8,
  parameter int GUARD_LONG  = 9,
  parameter int SLOTS       = 8,
  parameter int LONG_A      = 0,
  parameter int LONG_B      = 4,
  parameter int SLOT_W      = $clog2(SLOTS),
  parameter int IDX_W       = $clog2(2 * TAIL_LEN + FIXED_LEN + GUARD_LONG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              bitStrobe,
  output logic              dataBit,
  output logic              gateOn,
  output logic [SLOT_W-1:0] slotNum,
  output logic [IDX_W-1:0]  bitIdx,
  output logic              frameStart
);
  fcbCtrlT ctrl;

  fcbCtrl #(
    .TAIL_LEN(TAIL_LEN), .FIXED_LEN(FIXED_LEN), .GUARD_SHORT(GUARD_SHORT),
    .GUARD_LONG(GUARD_LONG), .SLOTS(SLOTS), .LONG_A(LONG_A), .LONG_B(LONG_B),
    .SLOT_W(SLOT_W), .IDX_W(IDX_W)
  ) uCtrl (
    .enable(enable), .bitStrobe(bitStrobe), .slotNum(slotNum),
    .bitIdx(bitIdx), .ctrl(ctrl)
  );

  fcbDatapath #(
    .SLOTS(SLOTS), .SLOT_W(SLOT_W), .IDX_W(IDX_W),
    .TAIL_VAL(1'b0), .FIXED_VAL(1'b0)
  ) uData (
    .clk(clk), .rst(rst), .ctrl(ctrl), .slotNum(slotNum), .bitIdx(bitIdx),
    .dataBit(dataBit), .gateOn(gateOn), .frameStart(frameStart)
  );
endmodule

// File: rtl/fcbChecker.sv
module fcbChecker #(
  parameter int TAIL_LEN    = 3,
  parameter int FIXED_LEN   = 142,
  parameter int GUARD_SHORT = 8,
  parameter int GUARD_LONG  = 9,
  parameter int SLOTS       = 8,
  parameter int LONG_A      = 0,
  parameter int LONG_B      = 4,
  parameter int SLOT_W      = 3,
  parameter int IDX_W       = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic              bitStrobe,
  input logic              dataBit,
  input logic              gateOn,
  input logic [SLOT_W-1:0] slotNum,
  input logic [IDX_W-1:0]  bitIdx,
  input logic              frameStart
);
  localparam int ACTIVE_LEN = 2 * TAIL_LEN + FIXED_LEN;
  logic            isLong;
  logic [IDX_W:0]  lastIdx;

  assign isLong  = (int'(slotNum) == LONG_A) || (int'(slotNum) == LONG_B);
  assign lastIdx = isLong ? (IDX_W+1)'(ACTIVE_LEN + GUARD_LONG - 1)
                          : (IDX_W+1)'(ACTIVE_LEN + GUARD_SHORT - 1);

  // R2
  hold_pos_chk: assert property (@(posedge clk) disable iff (rst)
    !(enable && bitStrobe) |=> $stable(slotNum) && $stable(bitIdx));

  // R3
  idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    {1'b0, bitIdx} <= lastIdx);

  // R4
  slot_step_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && bitStrobe && {1'b0, bitIdx} == lastIdx) |=>
      (bitIdx == '0) &&
      (int'(slotNum) == (int'($past(slotNum)) + 1) % SLOTS));

  // R5
  gate_guard_chk: assert property (@(posedge clk) disable iff (rst)
    gateOn |-> (int'(bitIdx) < ACTIVE_LEN));

  // R6
  data_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !dataBit);

  // R7
  frame_pos_chk: assert property (@(posedge clk) disable iff (rst)
    frameStart |-> (slotNum == '0) && (bitIdx == '0) && bitStrobe);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |-> !gateOn && !frameStart);
endmodule

bind fcBurstSeq fcbChecker #(
  .TAIL_LEN(TAIL_LEN), .FIXED_LEN(FIXED_LEN), .GUARD_SHORT(GUARD_SHORT),
  .GUARD_LONG(GUARD_LONG), .SLOTS(SLOTS), .LONG_A(LONG_A), .LONG_B(LONG_B),
  .SLOT_W(SLOT_W), .IDX_W(IDX_W)
) uChk (
  .clk(clk), .rst(rst), .enable(enable), .bitStrobe(bitStrobe),
  .dataBit(dataBit), .gateOn(gateOn), .slotNum(slotNum), .bitIdx(bitIdx),
  .frameStart(frameStart)
);

// File: tb/sim_fcBurstSeq.sv
`timescale 1ns/1ps
module sim_fcBurstSeq;
  logic clk = 1'b0;
  logic rst, enable, bitStrobe;
  logic dataBit, gateOn, frameStart;
  logic [2:0] slotNum;
  logic [7:0] bitIdx;

  int errors = 0, checks = 0;
  int refSlot = 0, refBit = 0;
  int strobesSinceFrame = -1;
  bit done = 0;

  always #5 clk = ~clk;

  fcBurstSeq u0 (
    .clk(clk), .rst(rst), .enable(enable), .bitStrobe(bitStrobe),
    .dataBit(dataBit), .gateOn(gateOn), .slotNum(slotNum), .bitIdx(bitIdx),
    .frameStart(frameStart)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (slot %0d bit %0d)",
               tag, what, act, exp, refSlot, refBit);
    end
  endtask

  function automatic int slotLen(int s);
    return (s == 0 || s == 4) ? 157 : 156;
  endfunction

  // Drive one cycle, compare, then advance the reference at the edge
  task automatic step(bit r, bit en, bit stb);
    string tag;
    @(negedge clk);
    rst = r; enable = en; bitStrobe = stb;
    #1;
    if (!r) begin
      tag = !en ? "R8" : (!stb ? "R2" : "R3");
      chk(tag, "bitIdx", int'(bitIdx), refBit);
      chk(!en ? "R8" : (!stb ? "R2" : "R4"), "slotNum", int'(slotNum), refSlot);
      chk(!en ? "R8" : "R5", "gateOn", int'(gateOn), (en && refBit < 148) ? 1 : 0);
      chk("R6", "dataBit", int'(dataBit), 0);
      chk(!en ? "R8" : "R7", "frameStart", int'(frameStart),
          (en && stb && refSlot == 0 && refBit == 0) ? 1 : 0);
    end
    @(posedge clk);
    if (r) begin
      refSlot = 0; refBit = 0; strobesSinceFrame = -1;
    end else if (en && stb) begin
      if (refSlot == 0 && refBit == 0) begin
        if (strobesSinceFrame >= 0) chk("R9", "frame period", strobesSinceFrame, 1250);
        strobesSinceFrame = 0;
      end
      if (strobesSinceFrame >= 0) strobesSinceFrame++;
      refBit++;
      if (refBit == slotLen(refSlot)) begin
        refBit = 0;
        refSlot = (refSlot + 1) % 8;
      end
    end
  endtask

  initial begin
    rst = 1'b1; enable = 1'b0; bitStrobe = 1'b0;
    repeat (3) step(1, 1, 1);
    // R1: reset state
    @(negedge clk); #1;
    chk("R1", "slotNum after reset", int'(slotNum), 0);
    chk("R1", "bitIdx after reset", int'(bitIdx), 0);
    // continuous strobes, two full frames plus
    for (int i = 0; i < 2600; i++) step(0, 1, 1);
    // sparse strobes every third cycle
    for (int i = 0; i < 1500; i++) step(0, 1, (i % 3) == 0);
    // irregular strobes with disable windows (R8)
    for (int i = 0; i < 3000; i++) begin
      bit en = ((i / 97) % 4) != 2;
      step(0, en, ((i * 7) % 5) < 3);
    end
    // mid-frame reset then run again
    step(1, 1, 1);
    for (int i = 0; i < 1400; i++) step(0, 1, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule